// File: doc/BRIEF.md
# Randomized Link Recovery Scheduler

This controller decides when a transceiver's link state is polled and when the transceiver is reset. It counts time in millisecond ticks supplied from outside. While polls keep finding the link up, the controller polls at a fixed period. When a poll finds the link down, it does three things in order. It raises a one-cycle request so that statistics can be captured. It drives a reset pulse of fixed length. It waits a settle period. After that it waits a random number of ticks drawn from a bounded window, and then it polls again.

The random wait is what makes recovery possible between two identical peers. Two peers built the same way, powered up together, would otherwise reset on the same schedule forever and never see each other's link. A 16-bit maximal-length LFSR advances every clock and supplies the random value. It is loaded from a seed input at reset. The block also flags every up-to-down change of the link input with a one-cycle event.

After its own reset, the block starts in the settle phase. The first poll therefore comes after the settle time plus one random wait. This also covers the rule that a reset is needed when no link forms within the minimum wait.

Top module: `link_recovery_sched`

## Requirements
- R1: When a poll samples link_up high, the next poll comes exactly UP_TICKS ticks later, whatever link_up does in between.
- R2: When a poll samples link_up low, the next poll comes SETTLE_TICKS + W ticks later. W is drawn from the inclusive range MIN_WAIT to MAX_WAIT, as MIN_WAIT + (LFSR value mod (MAX_WAIT - MIN_WAIT + 1)).
- R3: A drawn wait below one tick is raised to one tick, so a down-state wait is never zero.
- R4: A poll that samples link_up low raises snap_req for exactly the poll cycle, and phy_reset rises in the following cycle. snap_req never occurs without poll.
- R5: phy_reset stays high for exactly RST_CYCLES consecutive clocks, and it is low while rst is held.
- R6: After rst is released, the first poll comes SETTLE_TICKS + W ticks later, with W drawn as in R2.
- R7: The down-state waits vary from one retry to the next: a long run of retries shows at least three distinct intervals.
- R8: The LFSR is loaded from seed at reset. A seed of zero behaves exactly like the seed 16'hACE1, giving the same sequence of poll intervals.
- R9: A change of link_up from 1 to 0 produces a one-cycle link_loss pulse. It appears in the cycle after the first clock edge that sees link_up low.
- R10: A poll that samples link_up high produces neither snap_req nor phy_reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle time base pulse, one per millisecond |
| link_up | input | 1 | Current link status from the transceiver |
| seed | input | LFSR_W | LFSR load value, taken while rst is high |
| poll | output | 1 | One-cycle strobe: link status was sampled |
| phy_reset | output | 1 | Transceiver reset pulse, RST_CYCLES clocks long |
| snap_req | output | 1 | One-cycle request to capture statistics before a reset |
| link_loss | output | 1 | One-cycle event on an up-to-down link change |

## Verification
A wrong state shows up at the next poll. A timer that is loaded wrongly shifts the tick distance between two poll strobes, and a wrong branch decision shows as a snap_req or phy_reset that is missing or spurious in the poll cycle or the one after it. A broken reset counter changes the phy_reset width within a few clocks. A stuck or mis-reduced LFSR shows up within a few dozen retries, as a loss of variety in the down-state intervals or as an interval outside the window. A bad zero-seed fallback makes the zero-seed sequence differ from the sequence of its fixed substitute.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  typedef enum logic [2:0] {
    ST_UP_WAIT   = 3'd0,
    ST_DOWN_WAIT = 3'd1,
    ST_SNAPSHOT  = 3'd2,
    ST_RESET     = 3'd3,
    ST_SETTLE    = 3'd4
  } lrs_state_t;
endpackage

// File: rtl/lrs_lfsr.sv
module lrs_lfsr #(
  parameter int              W        = 16,
  parameter logic [W-1:0]    TAPS     = 16'hB400,
  parameter logic [W-1:0]    FALLBACK = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] seed,
  output logic [W-1:0] value
);
  logic [W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) st <= (seed == '0) ? FALLBACK : seed;
    else     st <= {st[W-2:0], ^(st & TAPS)};
  end

  assign value = st;

  // R8
  lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (rst) st != '0)
    else $error("lfsr reached the all-zero lock state");
endmodule

// File: rtl/lrs_tick_timer.sv
module lrs_tick_timer #(
  parameter int CNT_W   = 10,
  parameter int RST_VAL = 600
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                    cnt <= CNT_W'(RST_VAL);
    else if (load)              cnt <= load_val;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expire = tick && (cnt == CNT_W'(1));

  // R3
  load_nonzero_chk: assert property (@(posedge clk) disable iff (rst) load |-> load_val != '0)
    else $error("timer loaded with zero");
endmodule

// File: rtl/link_recovery_sched.sv
module link_recovery_sched #(
  parameter int UP_TICKS     = 1000,
  parameter int MIN_WAIT     = 100,
  parameter int MAX_WAIT     = 1000,
  parameter int SETTLE_TICKS = 600,
  parameter int RST_CYCLES   = 4,
  parameter int LFSR_W       = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ms_tick,
  input  logic              link_up,
  input  logic [LFSR_W-1:0] seed,
  output logic              poll,
  output logic              phy_reset,
  output logic              snap_req,
  output logic              link_loss
);
  import lrs_pkg::*;

  localparam int BIG_A   = (UP_TICKS > SETTLE_TICKS) ? UP_TICKS : SETTLE_TICKS;
  localparam int BIGGEST = (BIG_A > MAX_WAIT) ? BIG_A : MAX_WAIT;
  localparam int CNT_W   = $clog2(BIGGEST + 1);
  localparam int SPAN    = MAX_WAIT - MIN_WAIT + 1;
  localparam int RC_W    = $clog2(RST_CYCLES + 1);

  lrs_state_t        state;
  logic [RC_W-1:0]   rcnt;
  logic              link_q;
  logic [LFSR_W-1:0] rnd_raw;
  logic [CNT_W-1:0]  rnd_wait;
  logic              t_load;
  logic [CNT_W-1:0]  t_val;
  logic              t_exp;

  lrs_lfsr #(.W(LFSR_W)) u_lfsr (
    .clk(clk), .rst(rst), .seed(seed), .value(rnd_raw)
  );

  lrs_tick_timer #(.CNT_W(CNT_W), .RST_VAL(SETTLE_TICKS)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val),
    .tick(ms_tick), .expire(t_exp)
  );

  always_comb begin
    int r;
    r = MIN_WAIT + (int'(rnd_raw) % SPAN);
    if (r < 1) r = 1;
    rnd_wait = CNT_W'(r);
  end

  always_comb begin
    t_load = 1'b0;
    t_val  = rnd_wait;
    unique case (state)
      ST_UP_WAIT, ST_DOWN_WAIT: if (t_exp && link_up) begin
        t_load = 1'b1;
        t_val  = CNT_W'(UP_TICKS);
      end
      ST_RESET: if (rcnt == '0) begin
        t_load = 1'b1;
        t_val  = CNT_W'(SETTLE_TICKS);
      end
      ST_SETTLE: if (t_exp) t_load = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_SETTLE;
      rcnt      <= '0;
      link_q    <= 1'b0;
      poll      <= 1'b0;
      snap_req  <= 1'b0;
      phy_reset <= 1'b0;
      link_loss <= 1'b0;
    end else begin
      poll      <= 1'b0;
      snap_req  <= 1'b0;
      link_q    <= link_up;
      link_loss <= link_q & ~link_up;
      unique case (state)
        ST_UP_WAIT, ST_DOWN_WAIT: if (t_exp) begin
          poll <= 1'b1;
          if (link_up) state <= ST_UP_WAIT;
          else begin
            snap_req <= 1'b1;
            state    <= ST_SNAPSHOT;
          end
        end
        ST_SNAPSHOT: begin
          phy_reset <= 1'b1;
          rcnt      <= RC_W'(RST_CYCLES - 1);
          state     <= ST_RESET;
        end
        ST_RESET: begin
          if (rcnt == '0) begin
            phy_reset <= 1'b0;
            state     <= ST_SETTLE;
          end else begin
            rcnt <= rcnt - 1'b1;
          end
        end
        ST_SETTLE: if (t_exp) state <= ST_DOWN_WAIT;
        default: state <= ST_SETTLE;
      endcase
    end
  end

  // R4
  snap_then_rst_chk: assert property (@(posedge clk) disable iff (rst) snap_req |=> phy_reset)
    else $error("reset pulse did not follow snapshot request");

  // R4
  rst_after_snap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(phy_reset) |-> $past(snap_req))
    else $error("reset pulse without preceding snapshot request");

  // R10
  up_poll_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (poll && $past(link_up)) |-> (!snap_req && !phy_reset))
    else $error("poll with link up triggered recovery");

  // R9
  loss_single_chk: assert property (@(posedge clk) disable iff (rst) link_loss |=> !link_loss)
    else $error("link_loss longer than one cycle");
endmodule

// File: tb/sim_link_recovery_sched.sv
module sim_link_recovery_sched;
  localparam int UP_T   = 10;
  localparam int MINW   = 0;
  localparam int MAXW   = 5;
  localparam int SET_T  = 5;
  localparam int RST_C  = 4;
  localparam int TICK_P = 8;
  localparam int LOW_W  = (MINW < 1) ? 1 : MINW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_tick = 1'b0;
  logic link_up = 1'b0;
  logic [15:0] seed = 16'h0000;
  logic poll, phy_reset, snap_req, link_loss;

  int checks = 0;
  int errs = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  link_recovery_sched #(
    .UP_TICKS(UP_T), .MIN_WAIT(MINW), .MAX_WAIT(MAXW),
    .SETTLE_TICKS(SET_T), .RST_CYCLES(RST_C), .LFSR_W(16)
  ) u0 (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .link_up(link_up), .seed(seed),
    .poll(poll), .phy_reset(phy_reset), .snap_req(snap_req), .link_loss(link_loss)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // monitor state
  int tick_div, ticks, last_poll_t, n_polls, n_down, rst_run;
  bit prev_up, pend_snap, lp1, lp2;
  int rec [0:7];
  logic [63:0] seen_dn;

  always @(negedge clk) begin
    if (rst) begin
      ms_tick = 1'b0; tick_div = 0; ticks = 0; last_poll_t = 0; n_polls = 0;
      prev_up = 1'b0; pend_snap = 1'b0; rst_run = 0; lp1 = 1'b0; lp2 = 1'b0;
    end else begin
      chk(link_loss == (lp2 & ~lp1), "R9 link_loss", int'(link_loss), int'(lp2 & ~lp1));
      if (pend_snap) chk(phy_reset == 1'b1, "R4 reset after snapshot", int'(phy_reset), 1);
      pend_snap = snap_req;
      if (snap_req) chk(poll == 1'b1, "R4 snapshot only with poll", int'(poll), 1);
      if (phy_reset) rst_run++;
      else if (rst_run != 0) begin
        chk(rst_run == RST_C, "R5 reset width", rst_run, RST_C);
        rst_run = 0;
      end
      if (poll) begin
        automatic int iv = ticks - last_poll_t;
        if (prev_up) chk(iv == UP_T, "R1 up interval", iv, UP_T);
        else begin
          chk(iv >= SET_T + LOW_W && iv <= SET_T + MAXW,
              (n_polls == 0) ? "R6 first interval" : "R2/R3 down interval", iv, SET_T + LOW_W);
          seen_dn[iv] = 1'b1;
          n_down++;
        end
        if (n_polls < 8) rec[n_polls] = iv;
        if (lp1) chk(snap_req == 1'b0, "R10 no snapshot on up poll", int'(snap_req), 0);
        else     chk(snap_req == 1'b1, "R4 snapshot on down poll", int'(snap_req), 1);
        prev_up = lp1;
        last_poll_t = ticks;
        n_polls++;
      end
      lp2 = lp1;
      lp1 = link_up;
      tick_div++;
      if (tick_div == TICK_P) begin
        tick_div = 0;
        ms_tick = 1'b1;
        ticks++;
      end else ms_tick = 1'b0;
    end
  end

  task automatic set_link(input bit v);
    @(posedge clk); #2; link_up = v;
  endtask

  task automatic do_reset(input logic [15:0] s);
    @(posedge clk); #2; rst = 1'b1; seed = s;
    repeat (4) @(posedge clk);
    #2; rst = 1'b0;
  endtask

  task automatic wait_polls(input int n);
    while (n_polls < n) @(negedge clk);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errs);
  endtask

  initial begin
    int a [0:3];
    n_down = 0;
    seen_dn = '0;
    repeat (3) @(negedge clk);
    // R5: outputs quiet while reset is held
    chk(phy_reset == 1'b0, "R5 reset state phy_reset", int'(phy_reset), 0);
    chk(poll == 1'b0 && snap_req == 1'b0 && link_loss == 1'b0, "R5 reset state others",
        int'({poll, snap_req, link_loss}), 0);
    do_reset(16'h0000);
    wait_polls(4);
    for (int i = 0; i < 4; i++) a[i] = rec[i];
    // R8: zero seed must match the fallback seed
    do_reset(16'hACE1);
    wait_polls(4);
    for (int i = 0; i < 4; i++) chk(rec[i] == a[i], "R8 zero seed equals fallback", rec[i], a[i]);
    do_reset(16'h5A3C);
    wait_polls(30);
    set_link(1'b1);
    wait_polls(n_polls + 5);
    // drop the link in the middle of an up interval
    repeat (3 * TICK_P) @(negedge clk);
    set_link(1'b0);
    wait_polls(n_polls + 3);
    set_link(1'b1);
    wait_polls(n_polls + 3);
    set_link(1'b0);
    wait_polls(n_polls + 2);
    repeat (20) @(negedge clk);
    // R7: retries must show variety
    chk($countones(seen_dn) >= 3, "R7 distinct down intervals", $countones(seen_dn), 3);
    // R3: the zero draw must have been raised to one tick
    chk(seen_dn[SET_T + 1] == 1'b1, "R3 clamped wait seen", int'(seen_dn[SET_T + 1]), 1);
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule